// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block lets a host reach the configuration space of downstream devices through two narrow ports. The host first writes a 32-bit configuration address into the address port. A later access to the data port then becomes one configuration read or write on a downstream request interface. That request carries the bus number, the device/function number, the register offset, the access length and the write data. The downstream side answers in the same cycle with a presence indication, a function-0 presence indication and right-aligned read data.

Bit 31 of the stored address enables the data port. While it is clear, data-port traffic never leaves the block, and a data-port read returns all ones. A target is reachable only if a device answers at the decoded bus and device/function and that device's function 0 exists. A write to an unreachable target is dropped, and a read from one returns all ones. Host read results come back registered, one cycle after the request.

Top module: `cfg_port_bridge`

## Requirements
- R1: The address port takes a write only when the host offset is 0 and the length is exactly 4 bytes. Any other write to the address port leaves the stored address unchanged.
- R2: After reset the stored address is 0. A read of the address port (host_sel_i = 0) returns the stored 32-bit address unchanged.
- R3: While stored bit 31 is 0, a data-port access (host_sel_i = 1) raises neither dn_req_o nor dn_we_o, and a data-port read returns 32'hFFFF_FFFF.
- R4: The effective address is the stored address ORed with the 2-bit host offset. dn_bus_o carries its bits 23:16 and dn_devfn_o carries its bits 15:8.
- R5: dn_reg_o carries the effective address reduced to the 256-byte configuration space, which is its bits 7:0.
- R6: dn_len_o is the host length (1, 2 or 4) clipped to 256 minus dn_reg_o. For example, a 4-byte access at register 0xFE is sent as 2 bytes.
- R7: When dn_present_i is 0 during an enabled data access, dn_we_o stays 0 and a read returns 32'hFFFF_FFFF.
- R8: When dn_fn0_present_i is 0 during an enabled data access, the target is unreachable: dn_we_o stays 0 and a read returns 32'hFFFF_FFFF.
- R9: host_rvalid_o is 1 exactly one cycle after each read request (host_we_i = 0) and is 0 otherwise. In that cycle host_rdata_o holds that read's result, with a reachable device's dn_rdata_i passed through unchanged.
- R10: An enabled data write to a reachable target raises dn_we_o in the request cycle, with dn_wdata_o equal to host_wdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access strobe, one cycle per access |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_sel_i | input | 1 | 0 = address port, 1 = data port |
| host_off_i | input | 2 | Byte offset within the selected port |
| host_len_i | input | 3 | Access length in bytes (1, 2 or 4) |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered read result |
| host_rvalid_o | output | 1 | Read result valid, one cycle after the request |
| dn_req_o | output | 1 | Downstream configuration access strobe |
| dn_we_o | output | 1 | Downstream write commit, only for reachable targets |
| dn_bus_o | output | 8 | Decoded bus number |
| dn_devfn_o | output | 8 | Decoded device/function number |
| dn_reg_o | output | 8 | Register offset in configuration space |
| dn_len_o | output | 3 | Clipped access length in bytes |
| dn_wdata_o | output | 32 | Write data to the device |
| dn_present_i | input | 1 | A device answers at bus and device/function |
| dn_fn0_present_i | input | 1 | Function 0 of that device exists |
| dn_rdata_i | input | 32 | Right-aligned device read data |

## Verification
The registered read result of one access is presented in the same cycle that the next access is decoded. The sharpest overlap is a data-port read followed at once by an address-port write that clears the enable, and then by another data read. The bench issues these back to back with no idle cycle. It judges each result separately: the first read must show the device's data, the address write must produce no valid strobe, and the last read must return all ones with no downstream request.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CFG_BYTES = 256;
  localparam int unsigned REG_W     = $clog2(CFG_BYTES);
  localparam int unsigned LEN_W     = 3;
  localparam int unsigned EN_BIT    = 31;

  typedef struct packed {
    logic [7:0]       bus;
    logic [7:0]       devfn;
    logic [REG_W-1:0] reg_off;
    logic [LEN_W-1:0] len;
  } cfg_tgt_t;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= '0;
    else if (wr_en_i) addr_o <= wdata_i;
  end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_bridge_pkg::*;
(
  input  logic [DATA_W-1:0] addr_i,
  input  logic [1:0]        off_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              en_o,
  output cfg_tgt_t          tgt_o
);
  localparam int unsigned ROOM_W = REG_W + 1;

  logic [DATA_W-1:0] eff;
  logic [ROOM_W-1:0] room;
  logic [ROOM_W-1:0] len_ext;

  always_comb begin
    eff           = addr_i | {{(DATA_W-2){1'b0}}, off_i};
    en_o          = addr_i[EN_BIT];
    tgt_o.bus     = eff[23:16];
    tgt_o.devfn   = eff[15:8];
    tgt_o.reg_off = eff[REG_W-1:0];
    room          = ROOM_W'(CFG_BYTES) - {1'b0, eff[REG_W-1:0]};
    len_ext       = ROOM_W'(len_i);
    // clip so the access never runs past the end of config space
    tgt_o.len     = (len_ext > room) ? LEN_W'(room) : len_i;
  end
endmodule

// File: rtl/cfg_resp.sv
module cfg_resp
  import cfg_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_stb_i,
  input  logic [DATA_W-1:0] rd_val_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_stb_i;
      if (rd_stb_i) rdata_o <= rd_val_i;
    end
  end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic              host_sel_i,
  input  logic [1:0]        host_off_i,
  input  logic [LEN_W-1:0]  host_len_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rvalid_o,
  output logic              dn_req_o,
  output logic              dn_we_o,
  output logic [7:0]        dn_bus_o,
  output logic [7:0]        dn_devfn_o,
  output logic [REG_W-1:0]  dn_reg_o,
  output logic [LEN_W-1:0]  dn_len_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  input  logic              dn_present_i,
  input  logic              dn_fn0_present_i,
  input  logic [DATA_W-1:0] dn_rdata_i
);
  logic [DATA_W-1:0] cfg_q;
  logic              addr_acc, data_acc, addr_wr, en, reachable, rd_stb;
  logic [DATA_W-1:0] rd_val;
  cfg_tgt_t          tgt;

  assign addr_acc  = host_req_i & ~host_sel_i;
  assign data_acc  = host_req_i &  host_sel_i;
  assign addr_wr   = addr_acc & host_we_i & (host_off_i == 2'd0)
                   & (host_len_i == LEN_W'(4));
  assign reachable = dn_present_i & dn_fn0_present_i;
  assign rd_stb    = host_req_i & ~host_we_i;

  cfg_addr_reg u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (addr_wr),
    .wdata_i (host_wdata_i),
    .addr_o  (cfg_q)
  );

  cfg_decode u_dec (
    .addr_i (cfg_q),
    .off_i  (host_off_i),
    .len_i  (host_len_i),
    .en_o   (en),
    .tgt_o  (tgt)
  );

  assign dn_req_o   = data_acc & en;
  assign dn_we_o    = dn_req_o & host_we_i & reachable;
  assign dn_bus_o   = tgt.bus;
  assign dn_devfn_o = tgt.devfn;
  assign dn_reg_o   = tgt.reg_off;
  assign dn_len_o   = tgt.len;
  assign dn_wdata_o = host_wdata_i;

  always_comb begin
    if (addr_acc)                rd_val = cfg_q;
    else if (en && reachable)    rd_val = dn_rdata_i;
    else                         rd_val = '1;
  end

  cfg_resp u_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_stb_i (rd_stb),
    .rd_val_i (rd_val),
    .rdata_o  (host_rdata_o),
    .rvalid_o (host_rvalid_o)
  );
endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk
  import cfg_bridge_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_req_i,
  input logic              host_we_i,
  input logic              host_sel_i,
  input logic [1:0]        host_off_i,
  input logic [LEN_W-1:0]  host_len_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              host_rvalid_o,
  input logic              dn_req_o,
  input logic              dn_we_o,
  input logic [REG_W-1:0]  dn_reg_o,
  input logic [LEN_W-1:0]  dn_len_o,
  input logic              dn_present_i,
  input logic              dn_fn0_present_i,
  input logic [DATA_W-1:0] cfg_q
);
  // R1
  addr_wr_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_sel_i && host_we_i &&
    (host_off_i != 2'd0 || host_len_i != LEN_W'(4)) |=> cfg_q == $past(cfg_q));
  // R2
  addr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_sel_i && !host_we_i |=> host_rdata_o == $past(cfg_q));
  // R3
  disabled_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && host_sel_i && !cfg_q[EN_BIT] |-> !dn_req_o && !dn_we_o);
  // R3
  disabled_read_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && host_sel_i && !host_we_i && !cfg_q[EN_BIT] |=> host_rdata_o == '1);
  // R6
  len_clip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> ({1'b0, dn_reg_o} + (REG_W+1)'(dn_len_o)) <= (REG_W+1)'(CFG_BYTES));
  // R7
  write_needs_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_we_o |-> dn_present_i && dn_fn0_present_i);
  // R9
  rvalid_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_we_i |=> host_rvalid_o);
  // R9
  rvalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_req_i && !host_we_i) |=> !host_rvalid_o);
endmodule

bind cfg_port_bridge cfg_port_bridge_chk u_chk (.*);

// File: tb/cfg_port_bridge_tb.sv
module cfg_port_bridge_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_req_i = 1'b0, host_we_i = 1'b0, host_sel_i = 1'b0;
  logic [1:0]  host_off_i = '0;
  logic [2:0]  host_len_i = 3'd4;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] host_rdata_o;
  logic        host_rvalid_o;
  logic        dn_req_o, dn_we_o;
  logic [7:0]  dn_bus_o, dn_devfn_o, dn_reg_o;
  logic [2:0]  dn_len_o;
  logic [31:0] dn_wdata_o;
  logic        dn_present_i, dn_fn0_present_i;
  logic [31:0] dn_rdata_i;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cfg_port_bridge u_dut (.*);

  // device model: bus 0, slot 1 all functions; devfn 0x11 present without fn0
  logic [31:0] raw;
  always_comb begin
    dn_present_i     = (dn_bus_o == 8'd0) && (dn_devfn_o[7:3] == 5'd1 || dn_devfn_o == 8'h11);
    dn_fn0_present_i = (dn_devfn_o[7:3] == 5'd1);
    raw = {dn_bus_o, dn_devfn_o, dn_reg_o, 8'hA5};
    case (dn_len_o)
      3'd1: dn_rdata_i = {24'd0, raw[7:0]};
      3'd2: dn_rdata_i = {16'd0, raw[15:0]};
      3'd3: dn_rdata_i = {8'd0, raw[23:0]};
      default: dn_rdata_i = raw;
    endcase
  end

  logic        c_req, c_we;
  logic [7:0]  c_bus, c_devfn, c_reg;
  logic [2:0]  c_len;
  logic [31:0] c_wdata, r_data;
  logic        r_valid;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the request still driven
  task automatic access(logic sel, logic we, logic [1:0] off, logic [2:0] len, logic [31:0] wd);
    host_req_i = 1'b1; host_sel_i = sel; host_we_i = we;
    host_off_i = off; host_len_i = len; host_wdata_i = wd;
    #1;
    c_req = dn_req_o; c_we = dn_we_o; c_bus = dn_bus_o; c_devfn = dn_devfn_o;
    c_reg = dn_reg_o; c_len = dn_len_o; c_wdata = dn_wdata_o;
    @(negedge clk_i);
    r_data = host_rdata_o; r_valid = host_rvalid_o;
  endtask

  task automatic idle();
    host_req_i = 1'b0;
    @(negedge clk_i);
  endtask

  // {cfg, off, len, exp_rdata, exp_reg, exp_len}; exp_len 0 means no request expected
  localparam int NV = 10;
  localparam logic [79:0] VECS [NV] = '{
    {32'h8000_0810, 2'd0, 3'd4, 32'h0008_10A5, 8'h10, 3'd4},
    {32'h8000_0810, 2'd2, 3'd2, 32'h0000_12A5, 8'h12, 3'd2},
    {32'h8000_08FC, 2'd3, 3'd4, 32'h0000_00A5, 8'hFF, 3'd1},
    {32'h8000_08FC, 2'd1, 3'd4, 32'h0008_FDA5, 8'hFD, 3'd3},
    {32'h8000_08FC, 2'd2, 3'd4, 32'h0000_FEA5, 8'hFE, 3'd2},
    {32'h8000_0904, 2'd0, 3'd1, 32'h0000_00A5, 8'h04, 3'd1},
    {32'h8001_0800, 2'd0, 3'd4, 32'hFFFF_FFFF, 8'h00, 3'd4},
    {32'h8000_1100, 2'd0, 3'd4, 32'hFFFF_FFFF, 8'h00, 3'd4},
    {32'h0000_0810, 2'd0, 3'd4, 32'hFFFF_FFFF, 8'h10, 3'd0},
    {32'h8000_0801, 2'd2, 3'd4, 32'h0008_03A5, 8'h03, 3'd4}
  };

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 reset state
    chk("R9 rvalid after reset", 32'(host_rvalid_o), 32'd0);
    chk("R3 no req after reset", 32'(dn_req_o), 32'd0);
    access(1'b0, 1'b0, 2'd0, 3'd4, 32'd0);
    chk("R2 reset address", r_data, 32'd0);
    chk("R9 rvalid on read", 32'(r_valid), 32'd1);
    idle();

    // vector table: R4 R5 R6 R7 R8 R3 R9
    for (int i = 0; i < NV; i++) begin
      logic [31:0] cfg, exp;
      logic [1:0]  off;
      logic [2:0]  len, elen;
      logic [7:0]  ereg;
      {cfg, off, len, exp, ereg, elen} = VECS[i];
      access(1'b0, 1'b1, 2'd0, 3'd4, cfg);
      access(1'b1, 1'b0, off, len, 32'd0);
      chk($sformatf("R9/R7/R8/R3 rdata v%0d", i), r_data, exp);
      if (elen == 3'd0) begin
        chk($sformatf("R3 no req v%0d", i), 32'(c_req), 32'd0);
      end else begin
        chk($sformatf("R4 bus v%0d", i), 32'(c_bus), 32'(cfg[23:16]));
        chk($sformatf("R4 devfn v%0d", i), 32'(c_devfn), 32'(cfg[15:8]));
        chk($sformatf("R5 reg v%0d", i), 32'(c_reg), 32'(ereg));
        chk($sformatf("R6 len v%0d", i), 32'(c_len), 32'(elen));
      end
      idle();
    end

    // R1 rejected address writes
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_0810);
    access(1'b0, 1'b1, 2'd1, 3'd4, 32'h1234_5678);
    access(1'b0, 1'b1, 2'd0, 3'd2, 32'h0000_5678);
    access(1'b0, 1'b0, 2'd0, 3'd4, 32'd0);
    chk("R1 address unchanged", r_data, 32'h8000_0810);
    idle();

    // R10 enabled write to reachable device
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'hDEAD_BEEF);
    chk("R10 write strobe", 32'(c_we), 32'd1);
    chk("R10 write data", c_wdata, 32'hDEAD_BEEF);
    chk("R9 no rvalid after write", 32'(r_valid), 32'd0);
    idle();

    // R7 absent bus
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8002_0810);
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'h1111_1111);
    chk("R7 req issued", 32'(c_req), 32'd1);
    chk("R7 write dropped", 32'(c_we), 32'd0);
    // R8 function 0 absent
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_1100);
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'h2222_2222);
    chk("R8 write dropped", 32'(c_we), 32'd0);
    // R3 disabled write
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h0000_0810);
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'h3333_3333);
    chk("R3 disabled req", 32'(c_req), 32'd0);
    chk("R3 disabled write", 32'(c_we), 32'd0);
    idle();

    // back-to-back: read, disable, read
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_0810);
    access(1'b1, 1'b0, 2'd0, 3'd4, 32'd0);
    chk("R9 b2b first read", r_data, 32'h0008_10A5);
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h0000_0810);
    chk("R9 b2b no rvalid on addr write", 32'(r_valid), 32'd0);
    access(1'b1, 1'b0, 2'd0, 3'd4, 32'd0);
    chk("R3 b2b disabled req", 32'(c_req), 32'd0);
    chk("R3 b2b disabled read", r_data, 32'hFFFF_FFFF);
    chk("R9 b2b rvalid", 32'(r_valid), 32'd1);
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule